// File: doc/BRIEF.md
# Serial Voice CODEC Link with Transmit and Receive FIFOs

This block connects a simple peripheral register bus to an external serial voice CODEC and moves bytes in both directions at once. Software writes transmit bytes into a transmit FIFO and reads received bytes from a receive FIFO. The CODEC supplies both the serial bit clock and the frame sync, so the block is always the slave. Both inputs are brought into the system clock through two-flop synchronizers, and their edges are detected there. The system clock must run at least eight times faster than the serial clock.

A frame carries eight bits, most significant bit first. It starts on the first serial-clock rising edge on which frame sync is seen high. On that edge the block takes the next byte from the transmit FIFO and drives its top bit. It drives each later bit on the following rising edges. The serial input is sampled on each falling edge, and the assembled byte enters the receive FIFO after the eighth falling edge. The serial output is forced low unless transmit is enabled. A select output marks each frame as control (low) or data (high). A relay output and a ring-detect input are available as plain register bits. One active-high interrupt combines the masked FIFO level conditions and two sticky error flags.

Register map (word addresses): 0 = DATA (a write pushes a transmit byte from bits [7:0]; a read pops a receive byte and returns zero when the receive FIFO is empty). 1 = CTRL (bit0 transmit enable, bit1 frame select, bit2 relay, bits[7:4] interrupt mask: bit4 receive half, bit5 transmit half, bit6 overrun, bit7 underrun). 2 = STATUS (bit0 ring, bit1 overrun, bit2 underrun, bit3 receive FIFO holds at least DEPTH/2 bytes, bit4 transmit FIFO holds at most DEPTH/2 bytes, bits[15:8] transmit count, bits[23:16] receive count). Writing 1 to STATUS bit1 or bit2 clears that flag.

Top module: `codec_link`

## Requirements
- R1: After reset the serial output, select, relay and interrupt are low, both FIFO counts are zero, and STATUS reads 0x10.
- R2: With transmit enabled, a byte written to DATA appears on the serial output MSB first, one bit per serial rising edge, starting on the rising edge that sees frame sync high.
- R3: With transmit disabled, the serial output stays low for a whole frame, while the frame still consumes one transmit byte.
- R4: The serial input is sampled on falling edges. Each eight-bit frame is pushed to the receive FIFO MSB first, and bytes read back from DATA in arrival order; full duplex with R2.
- R5: A frame that starts with the transmit FIFO empty sends all zeros and sets the sticky underrun flag (STATUS bit2). Writing STATUS with bit2 set clears it.
- R6: A byte received while the receive FIFO is full is dropped, the count stays at DEPTH, the oldest byte is kept, and the sticky overrun flag (STATUS bit1) is set.
- R7: The select output follows CTRL bit1: low selects a control frame and high a data frame.
- R8: The relay output follows CTRL bit2, and the ring input is readable at STATUS bit0.
- R9: The interrupt is the OR of each CTRL mask bit[7:4] ANDed with its condition (receive half, transmit half, overrun, underrun). It is low when the mask is zero.
- R10: A DATA write to a full transmit FIFO is ignored. A DATA read of an empty receive FIFO returns zero and leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Block selected on the register bus |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | High for write, low for read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the strobe cycle |
| codec_sclk | input | 1 | Serial bit clock from the CODEC |
| codec_fsync | input | 1 | Frame sync from the CODEC |
| codec_sdi | input | 1 | Serial data from the CODEC |
| codec_sdo | output | 1 | Serial data to the CODEC, low unless transmit is enabled |
| codec_csel | output | 1 | Frame type select: 0 control, 1 data |
| ring_in | input | 1 | Ring-detect level |
| relay_out | output | 1 | Relay drive |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with FIFO_DEPTH set to 8, so the half-level point is 4 bytes and the full point is 8. With these values the receive-full overrun, the transmit-full ignored write and both half-level interrupt conditions are reached in a few serial frames. The serial clock runs at one sixteenth of the system clock. This leaves several system cycles between the synchronized edges, so the bench can sample the serial output in the middle of each bit.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  localparam int FRAME_BITS = 8;
  localparam int BUS_W      = 32;

  localparam int REG_DATA   = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_STATUS = 2;

  localparam int C_TXEN  = 0;
  localparam int C_CSEL  = 1;
  localparam int C_RELAY = 2;
  localparam int C_MASK  = 4;

  localparam int S_RING = 0;
  localparam int S_OVR  = 1;
  localparam int S_UNR  = 2;
  localparam int S_RXH  = 3;
  localparam int S_TXH  = 4;
  localparam int S_TXC  = 8;
  localparam int S_RXC  = 16;

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef struct packed {
    logic       underrun;
    logic       overrun;
    logic       tx_half;
    logic       rx_half;
  } irq_cond_t;

  function automatic logic irq_any(input logic [3:0] mask, input irq_cond_t cond);
    return |(mask & cond);
  endfunction
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_i;
      stage2 <= stage1;
    end
  end

  assign sync_o = stage2;
endmodule

// File: rtl/cl_fifo.sv
module cl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == FULLC);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  assign rdata_o = mem[rd_ptr];
  assign count_o = count;

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_o == FULLC));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (count_o == '0));
endmodule

// File: rtl/cl_serial.sv
module cl_serial
  import codec_link_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s_i,
  input  logic   fsync_s_i,
  input  logic   sdi_s_i,
  input  logic   tx_empty_i,
  input  frame_t tx_data_i,
  output logic   tx_pop_o,
  input  logic   rx_full_i,
  output logic   rx_push_o,
  output frame_t rx_data_o,
  output logic   sdo_bit_o,
  output logic   start_evt_o,
  output logic   underrun_evt_o,
  output logic   overrun_evt_o
);
  localparam int BCNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

  logic              sclk_prev;
  logic              rise_evt, fall_evt;
  logic              busy;
  logic [BCNT_W-1:0] bit_cnt;
  frame_t            tx_sh, rx_sh;
  logic              sdo_q;
  logic              rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s_i;
  end

  assign rise_evt    = sclk_s_i && !sclk_prev;
  assign fall_evt    = !sclk_s_i && sclk_prev;
  assign start_evt_o = rise_evt && !busy && fsync_s_i;
  assign rx_done     = fall_evt && busy && (bit_cnt == LAST_BIT);

  assign tx_pop_o       = start_evt_o && !tx_empty_i;
  assign underrun_evt_o = start_evt_o && tx_empty_i;
  assign rx_data_o      = {rx_sh[FRAME_BITS-2:0], sdi_s_i};
  assign rx_push_o      = rx_done && !rx_full_i;
  assign overrun_evt_o  = rx_done && rx_full_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (start_evt_o) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
        tx_sh   <= tx_empty_i ? '0 : tx_data_i;
        sdo_q   <= tx_empty_i ? 1'b0 : tx_data_i[FRAME_BITS-1];
      end else if (rise_evt && busy) begin
        sdo_q <= tx_sh[FRAME_BITS-2];
        tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      end
      if (fall_evt && busy) begin
        rx_sh   <= rx_data_o;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) busy <= 1'b0;
      end
    end
  end

  assign sdo_bit_o = sdo_q;

  p_underrun_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_o && tx_empty_i) |=> (sdo_bit_o == 1'b0));
  p_bit_per_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt) |=> $stable(sdo_bit_o));
  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_o) |-> !rx_full_i);
endmodule

// File: rtl/codec_link.sv
module codec_link
  import codec_link_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_stb,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              codec_sclk,
  input  logic              codec_fsync,
  input  logic              codec_sdi,
  output logic              codec_sdo,
  output logic              codec_csel,
  input  logic              ring_in,
  output logic              relay_out,
  output logic              irq
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

  logic       bus_wr, bus_rd;
  logic       sel_data, sel_ctrl, sel_status;
  logic [3:0] sync_in, sync_out;
  logic       sclk_s, fsync_s, sdi_s, ring_s;

  logic       ctrl_txen, ctrl_csel, ctrl_relay;
  logic [3:0] ctrl_mask;
  logic       flag_ovr, flag_unr;

  logic             tx_push, tx_pop, tx_empty, tx_full;
  frame_t           tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             rx_push, rx_pop, rx_empty, rx_full;
  frame_t           rx_head, rx_in;
  logic [CNT_W-1:0] rx_count;

  logic       sdo_bit, start_evt, unr_evt, ovr_evt;
  irq_cond_t  cond;
  logic [BUS_W-1:0] status_word;

  assign bus_wr     = bus_sel && bus_stb && bus_write;
  assign bus_rd     = bus_sel && bus_stb && !bus_write;
  assign sel_data   = (bus_addr == ADDR_W'(REG_DATA));
  assign sel_ctrl   = (bus_addr == ADDR_W'(REG_CTRL));
  assign sel_status = (bus_addr == ADDR_W'(REG_STATUS));

  assign sync_in = {ring_in, codec_sdi, codec_fsync, codec_sclk};

  cl_sync #(.WIDTH(4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sync_in),
    .sync_o  (sync_out)
  );

  assign sclk_s  = sync_out[0];
  assign fsync_s = sync_out[1];
  assign sdi_s   = sync_out[2];
  assign ring_s  = sync_out[3];

  assign tx_push = bus_wr && sel_data;
  assign rx_pop  = bus_rd && sel_data;

  cl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (tx_push),
    .wdata_i (bus_wdata[FRAME_BITS-1:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .count_o (tx_count)
  );

  cl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_push),
    .wdata_i (rx_in),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .count_o (rx_count)
  );

  cl_serial u_serial (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk_s_i       (sclk_s),
    .fsync_s_i      (fsync_s),
    .sdi_s_i        (sdi_s),
    .tx_empty_i     (tx_empty),
    .tx_data_i      (tx_head),
    .tx_pop_o       (tx_pop),
    .rx_full_i      (rx_full),
    .rx_push_o      (rx_push),
    .rx_data_o      (rx_in),
    .sdo_bit_o      (sdo_bit),
    .start_evt_o    (start_evt),
    .underrun_evt_o (unr_evt),
    .overrun_evt_o  (ovr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_txen  <= 1'b0;
      ctrl_csel  <= 1'b0;
      ctrl_relay <= 1'b0;
      ctrl_mask  <= '0;
    end else if (bus_wr && sel_ctrl) begin
      ctrl_txen  <= bus_wdata[C_TXEN];
      ctrl_csel  <= bus_wdata[C_CSEL];
      ctrl_relay <= bus_wdata[C_RELAY];
      ctrl_mask  <= bus_wdata[C_MASK +: 4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ovr <= 1'b0;
      flag_unr <= 1'b0;
    end else begin
      if (ovr_evt) flag_ovr <= 1'b1;
      else if (bus_wr && sel_status && bus_wdata[S_OVR]) flag_ovr <= 1'b0;
      if (unr_evt) flag_unr <= 1'b1;
      else if (bus_wr && sel_status && bus_wdata[S_UNR]) flag_unr <= 1'b0;
    end
  end

  assign cond.rx_half  = (rx_count >= HALF);
  assign cond.tx_half  = (tx_count <= HALF);
  assign cond.overrun  = flag_ovr;
  assign cond.underrun = flag_unr;

  always_comb begin
    status_word = '0;
    status_word[S_RING] = ring_s;
    status_word[S_OVR]  = flag_ovr;
    status_word[S_UNR]  = flag_unr;
    status_word[S_RXH]  = cond.rx_half;
    status_word[S_TXH]  = cond.tx_half;
    status_word[S_TXC +: CNT_W] = tx_count;
    status_word[S_RXC +: CNT_W] = rx_count;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data) begin
      if (!rx_empty) bus_rdata[FRAME_BITS-1:0] = rx_head;
    end else if (sel_ctrl) begin
      bus_rdata[C_TXEN]     = ctrl_txen;
      bus_rdata[C_CSEL]     = ctrl_csel;
      bus_rdata[C_RELAY]    = ctrl_relay;
      bus_rdata[C_MASK +: 4] = ctrl_mask;
    end else if (sel_status) begin
      bus_rdata = status_word;
    end
  end

  assign codec_sdo  = ctrl_txen && sdo_bit;
  assign codec_csel = ctrl_csel;
  assign relay_out  = ctrl_relay;
  assign irq        = irq_any(ctrl_mask, cond);

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> flag_ovr);
  p_underrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unr_evt |=> flag_unr);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_mask == 4'b0000) |-> !irq);
  p_pop_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !tx_empty) |-> tx_pop);
endmodule

// File: tb/codec_link_bench.sv
module codec_link_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_stb = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk = 1'b0, fsync = 1'b0, sdi = 1'b0, ring = 1'b0;
  logic        sdo, csel, relay, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_link #(.FIFO_DEPTH(DEPTH), .ADDR_W(AW)) u_codec_link (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_stb(bus_stb),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .codec_sclk(sclk), .codec_fsync(fsync),
    .codec_sdi(sdi), .codec_sdo(sdo), .codec_csel(csel), .ring_in(ring),
    .relay_out(relay), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_of(input bit rg, input bit ov, input bit un,
                                            input int txc, input int rxc);
    logic [31:0] s;
    s = 32'(txc) * 256 + 32'(rxc) * 65536;
    if (rg) s = s + 1;
    if (ov) s = s + 2;
    if (un) s = s + 4;
    if (rxc >= DEPTH / 2) s = s + 8;
    if (txc <= DEPTH / 2) s = s + 16;
    return s;
  endfunction

  task automatic bus_write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_stb = 1'b1; bus_write = 1'b1;
    bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_stb = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_read_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_stb = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_stb = 1'b0;
  endtask

  task automatic half_bit();
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] to_blk, output logic [7:0] from_blk);
    fsync = 1'b1; sdi = to_blk[7];
    half_bit();
    sclk = 1'b1;
    half_bit();
    from_blk[7] = sdo;
    fsync = 1'b0; sclk = 1'b0;
    half_bit();
    for (int i = 6; i >= 0; i--) begin
      sdi = to_blk[i];
      sclk = 1'b1;
      half_bit();
      from_blk[i] = sdo;
      sclk = 1'b0;
      half_bit();
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 sdo", 32'(sdo), 0);
    check("R1 csel", 32'(csel), 0);
    check("R1 relay", 32'(relay), 0);
    check("R1 irq", 32'(irq), 0);
    bus_read_reg(2, d);
    check("R1 status", d, 32'h10);
  endtask

  task automatic t_ctrl_pins();
    logic [31:0] d;
    bus_write_reg(1, 32'h6);
    check("R7 csel data frame", 32'(csel), 1);
    check("R8 relay on", 32'(relay), 1);
    bus_write_reg(1, 32'h0);
    check("R7 csel control frame", 32'(csel), 0);
    check("R8 relay off", 32'(relay), 0);
    ring = 1'b1;
    repeat (4) @(negedge clk);
    bus_read_reg(2, d);
    check("R8 ring bit", d & 32'h1, 1);
    ring = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_duplex();
    logic [7:0] got;
    logic [31:0] d;
    bus_write_reg(1, 32'h1);
    bus_write_reg(0, 32'hA5);
    frame(8'h3C, got);
    check("R2 sdo byte", 32'(got), 32'hA5);
    bus_read_reg(2, d);
    check("R4 status after frame", d, status_of(0, 0, 0, 0, 1));
    bus_read_reg(0, d);
    check("R4 rx byte", d, 32'h3C);
  endtask

  task automatic t_gate();
    logic [7:0] got;
    logic [31:0] d;
    bus_write_reg(1, 32'h0);
    bus_write_reg(0, 32'hFF);
    frame(8'h00, got);
    check("R3 sdo held low", 32'(got), 0);
    bus_read_reg(2, d);
    check("R3 byte consumed no underrun", d, status_of(0, 0, 0, 0, 1));
    bus_read_reg(0, d);
  endtask

  task automatic t_underrun();
    logic [7:0] got;
    logic [31:0] d;
    bus_write_reg(1, 32'h1);
    frame(8'h11, got);
    check("R5 zeros sent", 32'(got), 0);
    bus_read_reg(2, d);
    check("R5 underrun set", d, status_of(0, 0, 1, 0, 1));
    bus_write_reg(2, 32'h4);
    bus_read_reg(2, d);
    check("R5 underrun cleared", d, status_of(0, 0, 0, 0, 1));
    bus_read_reg(0, d);
  endtask

  task automatic t_order();
    logic [7:0] got;
    logic [7:0] sent [3] = '{8'h81, 8'h42, 8'h18};
    logic [7:0] recv [3] = '{8'hC3, 8'h5A, 8'h01};
    logic [31:0] d;
    bus_write_reg(1, 32'h3);
    for (int i = 0; i < 3; i++) bus_write_reg(0, 32'(sent[i]));
    for (int i = 0; i < 3; i++) begin
      frame(recv[i], got);
      check("R2 ordered sdo", 32'(got), 32'(sent[i]));
    end
    for (int i = 0; i < 3; i++) begin
      bus_read_reg(0, d);
      check("R4 ordered rx", d, 32'(recv[i]));
    end
  endtask

  task automatic t_overrun_irq();
    logic [7:0] got;
    logic [31:0] d;
    bus_write_reg(1, 32'h0);
    for (int i = 0; i < DEPTH; i++) frame(8'(8'h20 + i), got);
    frame(8'hEE, got);
    bus_read_reg(2, d);
    check("R6 overrun, count held", d, status_of(0, 1, 1, 0, DEPTH));
    bus_write_reg(1, 32'h10);
    check("R9 irq rx half", 32'(irq), 1);
    bus_write_reg(1, 32'h00);
    check("R9 irq masked off", 32'(irq), 0);
    bus_write_reg(1, 32'h40);
    check("R9 irq overrun", 32'(irq), 1);
    bus_write_reg(2, 32'h6);
    check("R9 irq after clear", 32'(irq), 0);
    bus_read_reg(0, d);
    check("R6 oldest kept", d, 32'h20);
    for (int i = 1; i < DEPTH; i++) bus_read_reg(0, d);
    check("R6 last stored", d, 32'(8'h20 + DEPTH - 1));
    bus_write_reg(1, 32'h20);
    check("R9 irq tx half", 32'(irq), 1);
    bus_write_reg(1, 32'h0);
  endtask

  task automatic t_limits();
    logic [31:0] d;
    for (int i = 0; i <= DEPTH; i++) bus_write_reg(0, 32'(i));
    bus_read_reg(2, d);
    check("R10 full tx write ignored", d, status_of(0, 0, 0, DEPTH, 0));
    bus_read_reg(0, d);
    check("R10 empty rx read", d, 0);
    bus_read_reg(2, d);
    check("R10 rx count stays zero", d, status_of(0, 0, 0, DEPTH, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_pins();
    t_duplex();
    t_gate();
    t_underrun();
    t_order();
    t_overrun_irq();
    t_limits();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule